// File: doc/BRIEF.md
# Privilege Gate and Flag Write Filter

This block decides, one request at a time, whether an instruction may go ahead under the current privilege state, and what may be committed when it does. Decode sits upstream and presents an instruction class code, the current privilege level, the I/O privilege threshold, the operating mode, a proposed new flag word with the old flag word, and the old and proposed protection-enable (PE) bits. Four enable bits also arrive with each request and govern a management-mode instruction class.

One cycle after a valid request, the block reports one of three results. It may raise a fault with vector 6 (invalid opcode) or 13 (general protection). It may give a filtered flag word together with its write enable. It may give a next PE value together with its write enable. Filtering is silent: a field the requester may not change keeps its old value and raises no fault. Flag storage and control-register storage are external and take the outputs only when the matching write enable is high.

Top module: `priv_gate`

## Requirements
- R1: Class 1 (privileged) raises a fault with vector 13 when the privilege level is not 0. At level 0 it raises no fault.
- R2: Class 2 (I/O-sensitive) raises vector 13 when the privilege level is numerically greater than the I/O threshold. Otherwise it raises no fault.
- R3: On class 3 (flag write), bit 9 (interrupt enable) keeps its old value when the privilege level is greater than the I/O threshold. Otherwise it takes the new value.
- R4: On a flag write, bits 13:12 (I/O threshold) and bit 17 (virtual mode) take the new values only at privilege level 0. At any other level they keep their old values.
- R5: In the committed flag word, every bit of mask 0x003F7FD5 outside bits 9, 12, 13 and 17 comes from the new word. Bit 1 reads 1. All other bits read 0.
- R6: Class 4 (status-word load) and class 5 (control-register move) raise vector 13 at any privilege level other than 0. Without a fault, class 4 commits old PE OR new PE, so it can set PE but never clear it. Class 5 commits the new PE unchanged.
- R7: Class 6 (protected-only) raises vector 6 in real mode (`prot_mode` = 0). In protected mode it raises no fault.
- R8: Class 7 (management) raises vector 6 unless all of the following hold: the management enable is 1, the region-size flag is 1, the privilege level is 0, and either the access bit or the in-handler bit is 1.
- R9: A faulting result has both write enables low. `flags_we` is high only for a class 3 result. `pe_we` is high only for a non-faulting class 4 or class 5 result. Class 0 gives no fault and no write.
- R10: Results appear exactly one cycle after `req_valid`, and `out_valid` marks them. Without a request, every strobe and enable is low. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| cls | input | 3 | Instruction class code (0 to 7) |
| cpl | input | 2 | Current privilege level |
| io_thr | input | 2 | I/O privilege threshold |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| new_flags | input | 32 | Proposed flag word |
| old_flags | input | 32 | Current flag word |
| old_pe | input | 1 | Current PE bit |
| new_pe | input | 1 | Proposed PE bit |
| mgmt_en | input | 1 | Management instruction enable |
| region_nz | input | 1 | Management region size is nonzero |
| mgmt_acc | input | 1 | Management access bit |
| in_handler | input | 1 | Execution is inside the management handler |
| out_valid | output | 1 | Result valid |
| fault | output | 1 | Fault raised |
| fault_vec | output | 8 | Fault vector (6 or 13) |
| flags_we | output | 1 | Commit filtered flag word |
| flags_out | output | 32 | Filtered flag word |
| pe_we | output | 1 | Commit next PE |
| pe_out | output | 1 | Next PE value |

## Verification
A flag write at a nonzero privilege level that is also above the I/O threshold engages the interrupt-enable filter and the threshold/virtual-mode filter in the same cycle. Likewise, a status-word load at a nonzero level has a fault that must suppress the one-way PE update. The bench reaches both cases by sweeping every class against every pairing of privilege level and threshold, both modes, all sixteen management-enable combinations and all four PE pairs, with random flag words. For each result it computes the expected fault, vector, enables and masked flag word in plain arithmetic and compares them field by field, then confirms that the following idle cycle carries no strobe.

// File: rtl/priv_gate_pkg.sv
// Package: shared widths, class codes and flag-bit positions for the privilege gate.
// Assumes a 32-bit flag word whose defined-bit layout is fixed by the positions below.
package priv_gate_pkg;
    localparam int FLAG_W   = 32;
    localparam int CLS_W    = 3;
    localparam int PL_W     = 2;
    localparam int VEC_W    = 8;

    localparam int IF_BIT   = 9;
    localparam int THR_LO   = 12;
    localparam int THR_HI   = 13;
    localparam int VM_BIT   = 17;
    localparam int ONE_BIT  = 1;

    localparam logic [VEC_W-1:0] VEC_UD = VEC_W'(6);
    localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);

    // Bits that carry meaning in the committed word; all others read 0 (bit 1 reads 1).
    localparam logic [FLAG_W-1:0] DEF_MASK = FLAG_W'(32'h003F_7FD5);
    localparam logic [FLAG_W-1:0] ONE_MASK = FLAG_W'(1) << ONE_BIT;
    localparam logic [FLAG_W-1:0] IF_MASK  = FLAG_W'(1) << IF_BIT;
    localparam logic [FLAG_W-1:0] THR_MASK = (FLAG_W'(1) << THR_LO) | (FLAG_W'(1) << THR_HI);
    localparam logic [FLAG_W-1:0] VM_MASK  = FLAG_W'(1) << VM_BIT;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN  = 3'd0,
        CLS_PRIV   = 3'd1,
        CLS_IOSENS = 3'd2,
        CLS_FLAGWR = 3'd3,
        CLS_MSWLD  = 3'd4,
        CLS_CRMOV  = 3'd5,
        CLS_PROT   = 3'd6,
        CLS_MGMT   = 3'd7
    } cls_e;
endpackage

// File: rtl/priv_fault_check.sv
// Module: combinational fault decision for one request.
// Assumes exactly one class per request, so at most one fault cause applies.
module priv_fault_check
    import priv_gate_pkg::*;
(
    input  cls_e              cls,
    input  logic [PL_W-1:0]   cpl,
    input  logic [PL_W-1:0]   io_thr,
    input  logic              prot_mode,
    input  logic              mgmt_en,
    input  logic              region_nz,
    input  logic              mgmt_acc,
    input  logic              in_handler,
    output logic              fault,
    output logic [VEC_W-1:0]  vec
);
    logic pl0;
    logic mgmt_ok;

    // Purpose: qualify the privilege-zero and management-permission terms.
    always_comb begin
        pl0     = (cpl == '0);
        mgmt_ok = mgmt_en && region_nz && pl0 && (mgmt_acc || in_handler);
    end

    // Purpose: choose fault presence and vector by instruction class.
    always_comb begin
        fault = 1'b0;
        vec   = '0;
        unique case (cls)
            CLS_PRIV, CLS_MSWLD, CLS_CRMOV: if (!pl0) begin
                fault = 1'b1;
                vec   = VEC_GP;
            end
            CLS_IOSENS: if (cpl > io_thr) begin
                fault = 1'b1;
                vec   = VEC_GP;
            end
            CLS_PROT: if (!prot_mode) begin
                fault = 1'b1;
                vec   = VEC_UD;
            end
            CLS_MGMT: if (!mgmt_ok) begin
                fault = 1'b1;
                vec   = VEC_UD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/priv_flag_filter.sv
// Module: builds the committed flag word from the new and old words.
// Assumes the field positions in priv_gate_pkg; fields that are not allowed to change are silently kept.
module priv_flag_filter
    import priv_gate_pkg::*;
(
    input  logic [PL_W-1:0]   cpl,
    input  logic [PL_W-1:0]   io_thr,
    input  logic [FLAG_W-1:0] new_flags,
    input  logic [FLAG_W-1:0] old_flags,
    output logic [FLAG_W-1:0] flags_out
);
    logic [FLAG_W-1:0] keep_sel;

    // Purpose: select the fields that must keep their old values.
    always_comb begin
        keep_sel = '0;
        if (cpl > io_thr) keep_sel = keep_sel | IF_MASK;
        if (cpl != '0)    keep_sel = keep_sel | THR_MASK | VM_MASK;
    end

    // Purpose: merge the words, clear undefined bits and force bit 1.
    always_comb begin
        flags_out = (((new_flags & ~keep_sel) | (old_flags & keep_sel)) & DEF_MASK) | ONE_MASK;
    end
endmodule

// File: rtl/priv_pe_next.sv
// Module: next protection-enable value for the two control-write paths.
// Assumes the status-word path may only set PE and the full register move may set or clear it.
module priv_pe_next
    import priv_gate_pkg::*;
(
    input  cls_e  cls,
    input  logic  old_pe,
    input  logic  new_pe,
    output logic  pe_wr,
    output logic  pe_val
);
    // Purpose: pick the PE update rule for the class.
    always_comb begin
        pe_wr  = 1'b0;
        pe_val = old_pe;
        if (cls == CLS_MSWLD) begin
            pe_wr  = 1'b1;
            pe_val = old_pe | new_pe;
        end else if (cls == CLS_CRMOV) begin
            pe_wr  = 1'b1;
            pe_val = new_pe;
        end
    end
endmodule

// File: rtl/priv_gate.sv
// Module: top of the privilege gate; registers the result one cycle after each request.
// Assumes decode supplies a stable class per request; storage of flags and PE is external.
module priv_gate
    import priv_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        cls,
    input  logic [1:0]        cpl,
    input  logic [1:0]        io_thr,
    input  logic              prot_mode,
    input  logic [31:0]       new_flags,
    input  logic [31:0]       old_flags,
    input  logic              old_pe,
    input  logic              new_pe,
    input  logic              mgmt_en,
    input  logic              region_nz,
    input  logic              mgmt_acc,
    input  logic              in_handler,
    output logic              out_valid,
    output logic              fault,
    output logic [7:0]        fault_vec,
    output logic              flags_we,
    output logic [31:0]       flags_out,
    output logic              pe_we,
    output logic              pe_out
);
    cls_e              cls_t;
    logic              f_nxt;
    logic [VEC_W-1:0]  v_nxt;
    logic [FLAG_W-1:0] fw_nxt;
    logic              pw_raw;
    logic              pv_nxt;

    // Purpose: view the raw class code as the enumerated type.
    always_comb cls_t = cls_e'(cls);

    priv_fault_check u_fault (
        .cls(cls_t), .cpl(cpl), .io_thr(io_thr), .prot_mode(prot_mode),
        .mgmt_en(mgmt_en), .region_nz(region_nz), .mgmt_acc(mgmt_acc),
        .in_handler(in_handler), .fault(f_nxt), .vec(v_nxt)
    );

    priv_flag_filter u_filt (
        .cpl(cpl), .io_thr(io_thr), .new_flags(new_flags),
        .old_flags(old_flags), .flags_out(fw_nxt)
    );

    priv_pe_next u_pe (
        .cls(cls_t), .old_pe(old_pe), .new_pe(new_pe),
        .pe_wr(pw_raw), .pe_val(pv_nxt)
    );

    // Purpose: register strobes and enables; a fault suppresses every commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fault     <= 1'b0;
            fault_vec <= '0;
            flags_we  <= 1'b0;
            pe_we     <= 1'b0;
        end else begin
            out_valid <= req_valid;
            fault     <= req_valid && f_nxt;
            fault_vec <= req_valid ? v_nxt : '0;
            flags_we  <= req_valid && !f_nxt && (cls_t == CLS_FLAGWR);
            pe_we     <= req_valid && !f_nxt && pw_raw;
        end
    end

    // Purpose: register the data words for the result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
            pe_out    <= 1'b0;
        end else if (req_valid) begin
            flags_out <= fw_nxt;
            pe_out    <= pv_nxt;
        end
    end
endmodule

// File: rtl/priv_gate_chk.sv
// Module: assertion checker attached to priv_gate by bind.
// Assumes port names identical to the top so that a wildcard connection applies.
module priv_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  cls,
    input logic [1:0]  cpl,
    input logic [1:0]  io_thr,
    input logic        prot_mode,
    input logic [31:0] old_flags,
    input logic        old_pe,
    input logic        out_valid,
    input logic        fault,
    input logic [7:0]  fault_vec,
    input logic        flags_we,
    input logic [31:0] flags_out,
    input logic        pe_we,
    input logic        pe_out
);
    a_r1_priv_gp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd1 && cpl != 2'd0) |=> (fault && fault_vec == 8'd13));

    a_r2_io_gp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd2 && cpl > io_thr) |=> (fault && fault_vec == 8'd13));

    a_r3_if_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd3 && cpl > io_thr) |=> (flags_out[9] == $past(old_flags[9])));

    a_r4_thr_vm_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd3 && cpl != 2'd0) |=>
        (flags_out[13:12] == $past(old_flags[13:12]) && flags_out[17] == $past(old_flags[17])));

    a_r5_bit1_set: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[1] && flags_out[31:22] == 10'd0));

    a_r6_pe_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd4 && old_pe && cpl == 2'd0) |=> (pe_we && pe_out));

    a_r7_real_ud: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cls == 3'd6 && !prot_mode) |=> (fault && fault_vec == 8'd6));

    a_r9_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!flags_we && !pe_we));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !fault && !flags_we && !pe_we));
endmodule

bind priv_gate priv_gate_chk u_chk (.*);

// File: tb/priv_gate_test.sv
// Bench: sweeps every class against privilege, threshold, mode, management and PE inputs.
module priv_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  cls = '0;
    logic [1:0]  cpl = '0;
    logic [1:0]  io_thr = '0;
    logic        prot_mode = 1'b0;
    logic [31:0] new_flags = '0;
    logic [31:0] old_flags = '0;
    logic        old_pe = 1'b0;
    logic        new_pe = 1'b0;
    logic        mgmt_en = 1'b0;
    logic        region_nz = 1'b0;
    logic        mgmt_acc = 1'b0;
    logic        in_handler = 1'b0;
    logic        out_valid, fault, flags_we, pe_we, pe_out;
    logic [7:0]  fault_vec;
    logic [31:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    priv_gate uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!out_valid && !fault && !flags_we && !pe_we && flags_out == 0 && !pe_out && fault_vec == 0,
            "R10 reset", {26'd0, out_valid, fault, flags_we, pe_we, pe_out, |flags_out}, 32'd0);
        for (int i = 0; i < 16384; i++) begin
            logic [13:0] s;
            bit e_f, e_fwe, e_pwe, e_pe, ok_m;
            logic [7:0]  e_v;
            logic [31:0] e_fl, keep;
            string ft;
            s = i[13:0];
            cls = s[2:0]; cpl = s[4:3]; io_thr = s[6:5]; prot_mode = s[7];
            {mgmt_en, region_nz, mgmt_acc, in_handler} = s[11:8];
            old_pe = s[12]; new_pe = s[13];
            new_flags = $urandom; old_flags = $urandom;
            req_valid = 1'b1;
            // expected result
            ok_m = mgmt_en && region_nz && cpl == 0 && (mgmt_acc || in_handler);
            e_f = 0; e_v = 0; ft = "R9 plain";
            case (cls)
                3'd1: begin e_f = cpl != 0; ft = "R1 priv"; end
                3'd2: begin e_f = cpl > io_thr; ft = "R2 iosens"; end
                3'd4, 3'd5: begin e_f = cpl != 0; ft = "R6 pe-path"; end
                3'd6: begin e_f = !prot_mode; ft = "R7 protonly"; end
                3'd7: begin e_f = !ok_m; ft = "R8 mgmt"; end
                default: ;
            endcase
            if (e_f) e_v = (cls >= 3'd6) ? 8'd6 : 8'd13;
            e_fwe = (cls == 3'd3);
            e_pwe = !e_f && (cls == 3'd4 || cls == 3'd5);
            e_pe  = (cls == 3'd4) ? (old_pe | new_pe) : new_pe;
            keep = 0;
            if (cpl > io_thr) keep[9] = 1'b1;
            if (cpl != 0) begin keep[13] = 1'b1; keep[12] = 1'b1; keep[17] = 1'b1; end
            e_fl = (((new_flags & ~keep) | (old_flags & keep)) & 32'h003F7FD5) | 32'h2;
            @(negedge clk);
            req_valid = 1'b0;
            chk(out_valid, "R10 latency", {31'd0, out_valid}, 32'd1);
            chk(fault == e_f && fault_vec == e_v, ft, {23'd0, fault, fault_vec}, {23'd0, e_f, e_v});
            chk(flags_we == e_fwe && pe_we == e_pwe, "R9 enables", {30'd0, flags_we, pe_we}, {30'd0, e_fwe, e_pwe});
            if (e_fwe) begin
                chk(flags_out[9] == e_fl[9], "R3 if-bit", {31'd0, flags_out[9]}, {31'd0, e_fl[9]});
                chk(flags_out[13:12] == e_fl[13:12] && flags_out[17] == e_fl[17], "R4 thr-vm",
                    {29'd0, flags_out[17], flags_out[13:12]}, {29'd0, e_fl[17], e_fl[13:12]});
                chk(flags_out == e_fl, "R5 word", flags_out, e_fl);
            end
            if (e_pwe)
                chk(pe_out == e_pe, "R6 pe", {31'd0, pe_out}, {31'd0, e_pe});
            @(negedge clk);
            chk(!out_valid && !fault && !flags_we && !pe_we, "R10 idle",
                {28'd0, out_valid, fault, flags_we, pe_we}, 32'd0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule